// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands one recoding step per clock. The multiplicand sits in a register of its own. The multiplier is loaded into the low half of a double-width result register, and one guard bit sits just below its least significant bit. On each step, the two lowest bits (result bit 0 and the guard bit) pick one of three actions on the upper half of the result: add the multiplicand, subtract it, or leave the upper half unchanged. The whole result register, together with the guard bit, then shifts right by one place arithmetically.

The surrounding logic loads the operands with separate strobes. It can clear the result register, and it starts a run with a one-cycle start pulse. Once the run begins, `busy` stays high for one cycle per operand bit. `done` pulses for one cycle when the product is ready. Between runs the result register appears unchanged on `product`. The operand width is a parameter with a default of 5 bits, which gives a 10-bit product. The upper-half arithmetic is one bit wider than the operand, so the most negative multiplicand gives the right result.

Top module: `booth_mult`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `product` is 0, `busy` is 0 and `done` is 0.
- R2: A `clearR` pulse while idle sets `product` to 0 from the next cycle on and clears the guard bit.
- R3: A `loadMr` pulse while idle (and without `clearR`) sets `product` to `mrIn` zero-extended, with the upper half 0, and clears the guard bit. If `clearR` and `loadMr` are both high, `clearR` wins.
- R4: A `loadMd` pulse while idle stores `mdIn` as the multiplicand used by every later run, until the next accepted `loadMd`.
- R5: A `start` pulse while idle raises `busy` in the next cycle. `busy` stays high for exactly OP_W cycles, and `done` is high for exactly one cycle: the first cycle after the last step, in which `busy` is already low.
- R6: In each step, the pair {product bit 0, guard bit} selects the action: 2'b10 subtracts the multiplicand from the upper half, 2'b01 adds it, and 2'b00 or 2'b11 leaves the upper half alone. The sum is OP_W+1 bits wide. Then {sum, low half} shifts right arithmetically by one, and old bit 0 becomes the guard bit.
- R7: When `done` is high, `product` equals the signed product of the loaded multiplicand and multiplier, as a 2*OP_W-bit two's-complement value, for every operand pair including the most negative values.
- R8: While `busy` is high, `clearR`, `loadMr`, `loadMd` and `start` have no effect.
- R9: With OP_W=5, a multiplicand of +8 (5'b01000) and a multiplier of -12 (5'b10100) give `product` = -96 (10'b1110100000).
- R10: Loads and `start` given in the same idle cycle take effect together, so the run uses the newly loaded values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clearR | input | 1 | Clear result register and guard bit |
| loadMd | input | 1 | Capture `mdIn` as multiplicand |
| loadMr | input | 1 | Capture `mrIn` into the low half of the result register |
| start | input | 1 | Begin a multiplication run |
| mdIn | input | OP_W | Multiplicand, two's complement |
| mrIn | input | OP_W | Multiplier, two's complement |
| product | output | 2*OP_W | Result register contents |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the product is valid |

## Verification
Every step's result register is visible on `product`, so a wrong selection between add, subtract and no operation, a wrong guard bit, or a logical shift in place of an arithmetic one shows at the port in the cycle right after the faulty step. The bench therefore compares `product` after every step, not only at `done`. A step counter that is off by one shows as a `busy` window of the wrong length, or as a `done` pulse in the wrong cycle, within OP_W+1 cycles of `start`. A multiplicand register that is overwritten during a run shows only in later results, so a run with no reload of the multiplicand follows the in-run disturbance.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic clearR;
    logic loadMd;
    logic loadMr;
    logic step;
  } boothStrobes_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } boothOp_t;

endpackage

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int OP_W = 5,
  localparam int AW = OP_W + 1
) (
  input  logic [OP_W-1:0] hiIn,
  input  logic [OP_W-1:0] mdIn,
  input  boothOp_t        op,
  output logic [AW-1:0]   accOut
);

  logic [AW-1:0] hiExt;
  logic [AW-1:0] mdExt;

  assign hiExt = {hiIn[OP_W-1], hiIn};
  assign mdExt = {mdIn[OP_W-1], mdIn};

  always_comb begin
    unique case (op)
      OP_ADD:  accOut = hiExt + mdExt;
      OP_SUB:  accOut = hiExt - mdExt;
      default: accOut = hiExt;
    endcase
  end

endmodule

// File: rtl/booth_dp.sv
module booth_dp
  import booth_pkg::*;
#(
  parameter int OP_W = 5,
  localparam int PW = 2 * OP_W,
  localparam int AW = OP_W + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  boothStrobes_t strobes,
  input  logic [OP_W-1:0] mdIn,
  input  logic [OP_W-1:0] mrIn,
  output logic [PW-1:0]   product
);

  logic [PW-1:0]   resReg;
  logic            guardBit;
  logic [OP_W-1:0] mdReg;
  boothOp_t        stepOp;
  logic [AW-1:0]   accOut;

  // Recode the two lowest bits into an action.
  always_comb begin
    unique case ({resReg[0], guardBit})
      2'b10:   stepOp = OP_SUB;
      2'b01:   stepOp = OP_ADD;
      default: stepOp = OP_NONE;
    endcase
  end

  booth_addsub #(.OP_W(OP_W)) u_addsub (
    .hiIn   (resReg[PW-1:OP_W]),
    .mdIn   (mdReg),
    .op     (stepOp),
    .accOut (accOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdReg <= '0;
    end else if (strobes.loadMd) begin
      mdReg <= mdIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg   <= '0;
      guardBit <= 1'b0;
    end else if (strobes.step) begin
      resReg   <= {accOut, resReg[OP_W-1:1]};
      guardBit <= resReg[0];
    end else if (strobes.clearR) begin
      resReg   <= '0;
      guardBit <= 1'b0;
    end else if (strobes.loadMr) begin
      resReg   <= {{OP_W{1'b0}}, mrIn};
      guardBit <= 1'b0;
    end
  end

  assign product = resReg;

  // R2: clearing empties the result register
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearR && !strobes.step) |=> (resReg == '0 && !guardBit));

  // R3: multiplier lands in the low half, upper half zero
  assert_load_mr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadMr && !strobes.clearR && !strobes.step)
      |=> (resReg == {{OP_W{1'b0}}, $past(mrIn)}));

  // R6: the guard bit takes the bit shifted out of position 0
  assert_guard_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (guardBit == $past(resReg[0])));

  // R6: with no action selected the upper half only shifts, keeping its sign
  assert_nop_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && (resReg[0] == guardBit))
      |=> (resReg[PW-1] == $past(resReg[PW-1])));

  // R4: multiplicand holds unless a load strobe arrives
  assert_md_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadMd |=> $stable(mdReg));

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int OP_W = 5,
  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clearR,
  input  logic          loadMd,
  input  logic          loadMr,
  input  logic          start,
  output boothStrobes_t strobes,
  output logic          busy,
  output logic          done
);

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(OP_W - 1);

  logic             runReg;
  logic             doneReg;
  logic [CNT_W-1:0] stepCnt;
  logic             lastStep;

  assign lastStep = runReg && (stepCnt == LAST_STEP);

  // Requests are honoured only while idle; a run only steps.
  always_comb begin
    strobes.clearR = !runReg && clearR;
    strobes.loadMd = !runReg && loadMd;
    strobes.loadMr = !runReg && loadMr && !clearR;
    strobes.step   = runReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg  <= 1'b0;
      doneReg <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneReg <= lastStep;
      if (!runReg) begin
        if (start) begin
          runReg  <= 1'b1;
          stepCnt <= '0;
        end
      end else if (lastStep) begin
        runReg  <= 1'b0;
        stepCnt <= '0;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign busy = runReg;
  assign done = doneReg;

  // R5: accepted start raises busy next cycle
  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!runReg && start) |=> runReg);

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |=> !doneReg);

  // R5: done follows exactly when busy drops
  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runReg) |-> doneReg);

  // R5: done never overlaps a run
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneReg |-> !runReg);

  // R8: a run ignores load and clear requests
  assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    runReg |-> !(strobes.clearR || strobes.loadMd || strobes.loadMr));

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int OP_W = 5,
  localparam int PW = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clearR,
  input  logic            loadMd,
  input  logic            loadMr,
  input  logic            start,
  input  logic [OP_W-1:0] mdIn,
  input  logic [OP_W-1:0] mrIn,
  output logic [PW-1:0]   product,
  output logic            busy,
  output logic            done
);

  boothStrobes_t strobes;

  booth_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clearR  (clearR),
    .loadMd  (loadMd),
    .loadMr  (loadMr),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  booth_dp #(.OP_W(OP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .mdIn    (mdIn),
    .mrIn    (mrIn),
    .product (product)
  );

endmodule

// File: tb/booth_mult_tb.sv
module booth_mult_tb;

  localparam int OP_W = 5;
  localparam int PW = 2 * OP_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearR = 1'b0, loadMd = 1'b0, loadMr = 1'b0, start = 1'b0;
  logic [OP_W-1:0] mdIn = '0, mrIn = '0;
  logic [PW-1:0] product;
  logic busy, done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  booth_mult #(.OP_W(OP_W)) u_dut (
    .clk(clk), .rstN(rstN), .clearR(clearR), .loadMd(loadMd),
    .loadMr(loadMr), .start(start), .mdIn(mdIn), .mrIn(mrIn),
    .product(product), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Step model written from the requirement text.
  task automatic modelStep(inout logic [PW-1:0] r, inout logic g,
                           input logic [OP_W-1:0] md);
    logic signed [OP_W:0] hi;
    logic signed [OP_W:0] m;
    logic [PW:0] wide;
    hi = $signed(r[PW-1:OP_W]);
    m  = $signed(md);
    if ({r[0], g} == 2'b10) hi = hi - m;
    else if ({r[0], g} == 2'b01) hi = hi + m;
    wide = {hi, r[OP_W-1:0]};
    g = r[0];
    r = wide[PW:1];
  endtask

  // Loads both operands with start in one idle cycle, then checks each step.
  // disturb > 0 injects junk requests in that step cycle.
  task automatic runMul(input logic [OP_W-1:0] md, input logic [OP_W-1:0] mr,
                        input bit doLoadMd, input int disturb,
                        input logic [OP_W-1:0] mdModel);
    logic [PW-1:0] r;
    logic g;
    int signed expProd;
    @(negedge clk);
    mdIn = md; mrIn = mr; loadMd = doLoadMd; loadMr = 1'b1; start = 1'b1;
    @(negedge clk);
    loadMd = 1'b0; loadMr = 1'b0; start = 1'b0;
    check("R5 busy after start", PW'(busy), PW'(1));
    check("R10 multiplier loaded with start", product, {{OP_W{1'b0}}, mr});
    r = {{OP_W{1'b0}}, mr};
    g = 1'b0;
    for (int k = 1; k <= OP_W; k++) begin
      if (k == disturb) begin
        clearR = 1'b1; loadMr = 1'b1; loadMd = 1'b1; start = 1'b1;
        mdIn = ~md; mrIn = ~mr;
      end
      @(negedge clk);
      clearR = 1'b0; loadMr = 1'b0; loadMd = 1'b0; start = 1'b0;
      modelStep(r, g, mdModel);
      check("R6 per-step result", product, r);
      check("R5 done only after last step", PW'(done), PW'(k == OP_W));
      check("R5 busy window", PW'(busy), PW'(k != OP_W));
    end
    expProd = $signed(mdModel) * $signed(mr);
    check("R7 signed product", product, PW'(expProd));
    @(negedge clk);
    check("R5 done single cycle", PW'(done), PW'(0));
    check("R8 product held when idle", product, PW'(expProd));
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    #3;
    check("R1 product in reset", product, '0);
    check("R1 busy in reset", PW'(busy), PW'(0));
    check("R1 done in reset", PW'(done), PW'(0));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 product after reset", product, '0);
    check("R1 done after reset", PW'(done), PW'(0));

    // R3: multiplier load
    mrIn = 5'b10110; loadMr = 1'b1;
    @(negedge clk);
    loadMr = 1'b0;
    check("R3 load multiplier", product, {{OP_W{1'b0}}, 5'b10110});

    // R2: clear
    clearR = 1'b1;
    @(negedge clk);
    clearR = 1'b0;
    check("R2 clear result", product, '0);

    // R3: clear beats load
    mrIn = 5'b01111; loadMr = 1'b1; clearR = 1'b1;
    @(negedge clk);
    loadMr = 1'b0; clearR = 1'b0;
    check("R3 clear wins over load", product, '0);

    // R9: +8 x -12
    runMul(5'b01000, 5'b10100, 1'b1, 0, 5'b01000);
    check("R9 plus8 times minus12", product, 10'b1110100000);

    // R7 / R6: exhaustive sweep
    for (int a = 0; a < (1 << OP_W); a++) begin
      for (int b = 0; b < (1 << OP_W); b++) begin
        runMul(OP_W'(a), OP_W'(b), 1'b1, 0, OP_W'(a));
      end
    end

    // R8: junk requests during each step position
    for (int d = 1; d <= OP_W; d++) begin
      runMul(5'b10011, 5'b01101, 1'b1, d, 5'b10011);
    end

    // R4: multiplicand kept across runs without reload (after in-run junk)
    runMul(5'b00001, 5'b11001, 1'b0, 0, 5'b10011);
    runMul(5'b00001, 5'b10000, 1'b0, 0, 5'b10011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule